// File: doc/BRIEF.md
# Coefficient Quantizer with Run-Time Reciprocal Table

This block turns a stream of signed transform coefficients into quantized values, one 8x8 block at a time. It never divides. Each coefficient is multiplied by an unsigned reciprocal of the step size for its frequency position. The block then rounds the product and clamps it to the output width. Software fills the 64-entry reciprocal table at run time. It normally loads a default step table scaled by a quality level: a larger level means larger steps, coarser output and more zero outputs.

The block also takes the same reduced block size setting that the transform uses. Coefficients that fall outside the low-frequency square of that size are sent out as zero, and the multiplier operands are held at zero for them. Coefficients arrive in raster order (row by row) on a valid/ready stream and leave in the same order on a second valid/ready stream.

Table writes are refused while a block is in flight, so every block is quantized against one consistent table.

Top module: `coef_quantizer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `tbl_reject` is 0, and every table entry holds 4096 (a step of 16).
- R2: Each output equals coefficient times the entry for its position (position = row*8 + column, counted in raster order from 0), divided by 65536 and rounded to nearest, with ties rounded away from zero.
- R3: Results above 1023 leave as 1023, and results below -1024 leave as -1024.
- R4: With a block size setting `vbs_sel` of 1 to 7, any position whose row or column is at least that value leaves as exactly 0. A setting of 0 or of 8 and above selects the full block. The setting is sampled with the first coefficient of a block and held for the remaining 63.
- R5: A table write issued while no block is in flight updates the addressed entry, does not raise `tbl_reject`, and is used by every later block.
- R6: A table write issued while a block is in flight leaves the table unchanged. `tbl_reject` pulses high for one cycle, one cycle after the write. A block is in flight from the cycle its first coefficient is accepted until its 64th is accepted.
- R7: With `out_ready` held high, a coefficient presented and accepted in cycle n appears on `out_coef` with `out_valid` high in cycle n+2.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_coef` hold their values and `in_ready` is low.
- R9: Blocks follow each other with no gap. Every 64 accepted coefficients close one block, and the next accepted coefficient is position 0 of a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input coefficient is valid |
| in_ready | output | 1 | Block can accept a coefficient this cycle |
| in_coef | input | 12 | Signed input coefficient |
| vbs_sel | input | 4 | Active square size, sampled at the start of a block |
| out_valid | output | 1 | Output value is valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_coef | output | 11 | Signed quantized coefficient |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table position to write |
| tbl_data | input | 16 | Reciprocal value, 65536 divided by the step |
| tbl_reject | output | 1 | One-cycle pulse when a write was refused |

## Verification
The assertions assume that `tbl_we`, `in_valid` and `out_ready` are known, not X, in every cycle after reset. They also assume a refused write is meaningful only for the single cycle in which it is presented, since the strobe is not held. The bench changes every input on the falling clock edge and lowers the write strobe after one cycle. It sends mid-block writes only while the output side is always ready, so that each refused write lands in exactly one rising edge while the block is in flight.

// File: rtl/cq_pkg.sv
package cq_pkg;

  localparam int unsigned CQ_DIM     = 8;
  localparam int unsigned CQ_COEF_W  = 12;
  localparam int unsigned CQ_RECIP_W = 16;
  localparam int unsigned CQ_OUT_W   = 11;
  localparam int unsigned CQ_FRAC    = 16;
  localparam int unsigned CQ_VBS_W   = 4;

  // Shift a fixed-point product right by frac bits, ties away from zero.
  function automatic logic signed [63:0] cq_round_away(input logic signed [63:0] prod,
                                                       input int unsigned frac);
    logic signed [63:0] mag;
    logic signed [63:0] half;
    logic signed [63:0] q;
    half = 64'sd1 <<< (frac - 1);
    mag  = (prod < 0) ? -prod : prod;
    q    = (mag + half) >>> frac;
    return (prod < 0) ? -q : q;
  endfunction

  // Clamp to the range of a signed value of the given width.
  function automatic logic signed [63:0] cq_saturate(input logic signed [63:0] v,
                                                     input int unsigned bits);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (bits - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/cq_recip_table.sv
module cq_recip_table #(
  parameter int unsigned NPOS      = 64,
  parameter int unsigned RECIP_W   = 16,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned RESET_VAL = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [RECIP_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [RECIP_W-1:0] rd_data
);

  logic [RECIP_W-1:0] entry [NPOS];

  for (genvar g = 0; g < NPOS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[g] <= RECIP_W'(RESET_VAL);
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        entry[g] <= wr_data;
    end
  end

  assign rd_data = entry[rd_addr];

endmodule

// File: rtl/cq_block_tracker.sv
module cq_block_tracker #(
  parameter int unsigned DIM    = 8,
  parameter int unsigned VBS_W  = 4,
  parameter int unsigned AXIS_W = 3,
  parameter int unsigned POS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [VBS_W-1:0] vbs_in,
  output logic [POS_W-1:0] pos,
  output logic             active,
  output logic             busy
);

  localparam int unsigned NPOS = DIM * DIM;

  logic [POS_W-1:0]  cnt_q;
  logic [VBS_W-1:0]  vbs_q;
  logic [VBS_W-1:0]  vbs_eff;
  logic [VBS_W-1:0]  lim;
  logic [AXIS_W-1:0] row;
  logic [AXIS_W-1:0] col;
  logic              block_start;

  assign block_start = (cnt_q == '0);
  assign vbs_eff     = block_start ? vbs_in : vbs_q;
  assign lim         = ((vbs_eff == '0) || (vbs_eff >= VBS_W'(DIM))) ? VBS_W'(DIM) : vbs_eff;

  assign row    = cnt_q[POS_W-1:AXIS_W];
  assign col    = cnt_q[AXIS_W-1:0];
  assign active = (VBS_W'(row) < lim) && (VBS_W'(col) < lim);
  assign pos    = cnt_q;
  assign busy   = !block_start || accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vbs_q <= VBS_W'(DIM);
    end else if (accept) begin
      cnt_q <= (cnt_q == POS_W'(NPOS - 1)) ? '0 : cnt_q + 1'b1;
      if (block_start) vbs_q <= vbs_in;
    end
  end

endmodule

// File: rtl/cq_scale_stage.sv
module cq_scale_stage
  import cq_pkg::*;
#(
  parameter int unsigned COEF_W  = 12,
  parameter int unsigned RECIP_W = 16,
  parameter int unsigned OUT_W   = 11,
  parameter int unsigned FRAC    = 16
) (
  input  logic                     enable,
  input  logic signed [COEF_W-1:0] coef,
  input  logic [RECIP_W-1:0]       recip,
  output logic signed [OUT_W-1:0]  result
);

  localparam int unsigned PROD_W = COEF_W + RECIP_W + 1;

  logic signed [COEF_W-1:0]  coef_g;
  logic signed [RECIP_W:0]   recip_g;
  logic signed [PROD_W-1:0]  prod;
  logic signed [63:0]        prod_w;
  logic signed [63:0]        shaped;

  // Operands held at zero for skipped positions: the multiplier stays idle.
  assign coef_g  = enable ? coef : '0;
  assign recip_g = enable ? $signed({1'b0, recip}) : '0;
  assign prod    = coef_g * recip_g;
  assign prod_w  = 64'(prod);
  assign shaped  = cq_saturate(cq_round_away(prod_w, FRAC), OUT_W);
  assign result  = shaped[OUT_W-1:0];

endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
  import cq_pkg::*;
#(
  parameter int unsigned DIM         = CQ_DIM,
  parameter int unsigned COEF_W      = CQ_COEF_W,
  parameter int unsigned RECIP_W     = CQ_RECIP_W,
  parameter int unsigned OUT_W       = CQ_OUT_W,
  parameter int unsigned FRAC        = CQ_FRAC,
  parameter int unsigned VBS_W       = CQ_VBS_W,
  parameter int unsigned RESET_RECIP = 4096
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [COEF_W-1:0] in_coef,
  input  logic [VBS_W-1:0]         vbs_sel,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_coef,
  input  logic                     tbl_we,
  input  logic [5:0]               tbl_addr,
  input  logic [RECIP_W-1:0]       tbl_data,
  output logic                     tbl_reject
);

  localparam int unsigned NPOS   = DIM * DIM;
  localparam int unsigned POS_W  = $clog2(NPOS);
  localparam int unsigned AXIS_W = $clog2(DIM);

  // Pipeline control
  logic advance;
  logic accept;

  // Position tracking
  logic [POS_W-1:0] pos;
  logic             pos_active;
  logic             busy;

  // Table access
  logic               wr_ok;
  logic [RECIP_W-1:0] rd_recip;

  // Stage 1
  logic                     s1_v;
  logic                     s1_act;
  logic signed [COEF_W-1:0] s1_coef;
  logic [RECIP_W-1:0]       s1_recip;

  // Stage 2 (output)
  logic                     out_v_q;
  logic signed [OUT_W-1:0]  out_q;
  logic signed [OUT_W-1:0]  scaled;
  logic                     reject_q;

  // Named events for the checker
  logic mul_fire;
  logic skip_fire;

  assign advance  = !out_v_q || out_ready;
  assign accept   = in_valid && advance;
  assign in_ready = advance;
  assign wr_ok    = tbl_we && !busy;

  cq_block_tracker #(
    .DIM   (DIM),
    .VBS_W (VBS_W),
    .AXIS_W(AXIS_W),
    .POS_W (POS_W)
  ) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .vbs_in(vbs_sel),
    .pos   (pos),
    .active(pos_active),
    .busy  (busy)
  );

  cq_recip_table #(
    .NPOS     (NPOS),
    .RECIP_W  (RECIP_W),
    .ADDR_W   (POS_W),
    .RESET_VAL(RESET_RECIP)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ok),
    .wr_addr(POS_W'(tbl_addr)),
    .wr_data(tbl_data),
    .rd_addr(pos),
    .rd_data(rd_recip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_act   <= 1'b0;
      s1_coef  <= '0;
      s1_recip <= '0;
    end else if (advance) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_act   <= pos_active;
        s1_coef  <= in_coef;
        s1_recip <= rd_recip;
      end
    end
  end

  cq_scale_stage #(
    .COEF_W (COEF_W),
    .RECIP_W(RECIP_W),
    .OUT_W  (OUT_W),
    .FRAC   (FRAC)
  ) u_scale (
    .enable(s1_act),
    .coef  (s1_coef),
    .recip (s1_recip),
    .result(scaled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else if (advance) begin
      out_v_q <= s1_v;
      if (s1_v) out_q <= scaled;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reject_q <= 1'b0;
    else        reject_q <= tbl_we && busy;
  end

  assign mul_fire  = advance && s1_v && s1_act;
  assign skip_fire = advance && s1_v && !s1_act;

  assign out_valid  = out_v_q;
  assign out_coef   = out_q;
  assign tbl_reject = reject_q;

endmodule

// File: rtl/coef_quantizer_chk.sv
module coef_quantizer_chk #(
  parameter int unsigned OUT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_coef,
  input logic             tbl_we,
  input logic             tbl_reject,
  input logic             busy,
  input logic             mul_fire,
  input logic             skip_fire
);

  assert_skip_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    skip_fire |=> (out_valid && (out_coef == '0)));

  assert_mul_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |=> out_valid);

  assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef)));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_refuse_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && busy) |=> tbl_reject);

  assert_accept_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !busy) |=> !tbl_reject);

  assert_quiet_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_we |=> !tbl_reject);

endmodule

bind coef_quantizer coef_quantizer_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_coef  (out_coef),
  .tbl_we    (tbl_we),
  .tbl_reject(tbl_reject),
  .busy      (busy),
  .mul_fire  (mul_fire),
  .skip_fire (skip_fire)
);

// File: tb/coef_quantizer_test.sv
`timescale 1ns/1ps
module coef_quantizer_test;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic               in_ready;
  logic signed [11:0] in_coef;
  logic [3:0]         vbs_sel;
  logic               out_valid;
  logic               out_ready;
  logic signed [10:0] out_coef;
  logic               tbl_we;
  logic [5:0]         tbl_addr;
  logic [15:0]        tbl_data;
  logic               tbl_reject;

  always #2.5 clk = ~clk;

  coef_quantizer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .vbs_sel(vbs_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_coef(out_coef), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .tbl_reject(tbl_reject)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  bit    rand_ready = 1'b0;
  int    model_tbl [64];
  int    q_exp [$];
  int    q_cyc [$];
  bit    q_lat [$];
  string q_tag [$];
  bit    prev_stall = 1'b0;
  int    prev_val = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected value by integer division of the magnitude (R2, R3).
  function automatic int expect_q(input int c, input int r, input bit act);
    longint p;
    longint m;
    longint q;
    if (!act) return 0;
    p = longint'(c) * longint'(r);
    m = (p < 0) ? -p : p;
    q = m / 65536;
    if ((m % 65536) >= 32768) q = q + 1;
    if (p < 0) q = -q;
    if (q > 1023) q = 1023;
    if (q < -1024) q = -1024;
    return int'(q);
  endfunction

  function automatic int gen(input int kind, input int i);
    case (kind)
      0: return ((i * 37) % 4096) - 2048;
      1: return (i % 2 == 0) ? 2047 : -2048;
      2: return (i % 7) - 3;
      default: return ((i * i * 13 + kind * 101) % 4096) - 2048;
    endcase
  endfunction

  task automatic send_block(input int kind, input int vbs_first, input int vbs_later,
                            input int inj_at, input int inj_addr, input int inj_data,
                            input string tag);
    int lim;
    lim = (vbs_first == 0 || vbs_first >= 8) ? 8 : vbs_first;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (inj_at >= 0 && i == inj_at + 1) begin
        #0.2;
        check(tbl_reject == 1'b1, "R6 refused write flag", int'(tbl_reject), 1);
        tbl_we = 1'b0;
      end
      in_valid = 1'b1;
      in_coef  = 12'(gen(kind, i));
      vbs_sel  = (i == 0) ? 4'(vbs_first) : 4'(vbs_later);
      if (i == inj_at) begin
        tbl_we = 1'b1; tbl_addr = 6'(inj_addr); tbl_data = 16'(inj_data);
      end
      #0.5;
      while (!in_ready) begin
        @(negedge clk);
        #0.5;
      end
      q_exp.push_back(expect_q(gen(kind, i), model_tbl[i], ((i / 8) < lim) && ((i % 8) < lim)));
      q_cyc.push_back(cyc);
      q_lat.push_back(!rand_ready);
      q_tag.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
    tbl_we   = 1'b0;
  endtask

  task automatic tbl_write(input int addr, input int data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 6'(addr); tbl_data = 16'(data);
    @(negedge clk);
    tbl_we = 1'b0;
    #0.2;
    check(tbl_reject == 1'b0, "R5 idle write accepted", int'(tbl_reject), 0);
    model_tbl[addr] = data;
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && q_exp.size() > 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R9 all outputs delivered", q_exp.size(), 0);
  endtask

  // Monitor: scoreboard comparison and hold check.
  always @(negedge clk) begin
    out_ready = rand_ready ? ($urandom % 3 != 0) : 1'b1;
    #1;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && (int'(out_coef) == prev_val), "R8 held output",
              int'(out_coef), prev_val);
      prev_stall = out_valid && !out_ready;
      prev_val   = int'(out_coef);
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R9 unexpected output", int'(out_coef), 0);
        end else begin
          int    e;
          int    c0;
          bit    l;
          string t;
          e = q_exp.pop_front(); c0 = q_cyc.pop_front();
          l = q_lat.pop_front(); t = q_tag.pop_front();
          check(int'(out_coef) == e, t, int'(out_coef), e);
          if (l) check(cyc == c0 + 2, "R7 two-cycle latency", cyc - c0, 2);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=0", q_exp.size());
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model_tbl[i] = 4096;
    rst_n = 1'b0; in_valid = 1'b0; in_coef = '0; vbs_sel = 4'd8;
    tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
    repeat (3) @(negedge clk);
    #1.2;
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    check(tbl_reject == 1'b0, "R1 reset tbl_reject", int'(tbl_reject), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 default table, R2 ramp data, R7 timing, R9 back-to-back blocks
    send_block(0, 8, 8, -1, 0, 0, "R1 R2 default table");
    send_block(5, 8, 8, -1, 0, 0, "R9 second block");
    drain();

    // R5 table rewrite, R3 saturation, R2 tie rounding
    for (int i = 0; i < 8; i++) tbl_write(i, 65535);
    tbl_write(8, 1);
    tbl_write(9, 32768);
    tbl_write(10, 32768);
    tbl_write(11, 21845);
    send_block(1, 0, 0, -1, 0, 0, "R3 saturation");
    send_block(2, 8, 8, -1, 0, 0, "R2 tie rounding");
    drain();

    // R4 reduced squares, setting held for the whole block
    send_block(3, 5, 8, -1, 0, 0, "R4 size 5");
    send_block(0, 1, 8, -1, 0, 0, "R4 size 1");
    send_block(4, 3, 1, -1, 0, 0, "R4 size held");
    send_block(6, 15, 2, -1, 0, 0, "R4 size 15 full");
    drain();

    // R6 refused write mid block, table unchanged in same and next block
    send_block(0, 8, 8, 10, 20, 1234, "R6 same block");
    send_block(0, 8, 8, -1, 0, 0, "R6 next block");
    drain();

    // R8 random backpressure
    rand_ready = 1'b1;
    send_block(7, 8, 8, -1, 0, 0, "R8 stalled data");
    send_block(1, 6, 8, -1, 0, 0, "R8 stalled size 6");
    drain();
    rand_ready = 1'b0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule